// File: doc/BRIEF.md
# AC-link Codec Register Access Unit

This block lets a host program the control registers of an external audio codec over an AC'97-style link. The host stages a command in two holding registers: one for the command-data slot (slot 2) and one for the command-address slot (slot 1). The slot-1 word carries a read-request flag next to the register index. Loading slot 1 launches the command. The next outgoing frame then carries slot 1, and slot 2 as well when it is pending. A 2-bit field picks which of up to four codecs is addressed.

On the receive side, the frame logic first marks which status slots an incoming frame carries. It then delivers the slot words one strobe later. The block keeps the most recent status address word and status data word and flags each as valid until the host reads it. A single flag register reports per-slot transmit busy, transmit empty, receive busy and receive valid. The bit positions are fixed so that existing software can decode them.

The frame side is a plain strobe interface. Serial bit timing, PCM audio slots and modem slot data belong to neighbouring logic.

Top module: `codec_reg_access`

## Requirements
- R1: After reset the flag register reads 0x0A80, the control register reads 0, and both outgoing slot tag-valid outputs are low.
- R2: The outgoing slot-1 word keeps bits 19:12 of the last slot-1 host write (bit 19 = 1 read request, bit 19 = 0 write; bits 18:12 register index) and drives all other bits as zero.
- R3: The outgoing slot-2 word keeps bits 19:4 of the last slot-2 host write (16-bit command data) and drives bits 3:0 as zero.
- R4: Slot 2 never goes out on its own. Its tag-valid output is high only while slot 1 is also tagged, and it is emitted in the same frame as slot 1.
- R5: A slot's transmit busy flag rises and its transmit empty flag falls in the cycle after the host write. Both return to their idle values after an outgoing frame strobe that emits the slot.
- R6: While a slot's transmit enable is clear, its tag-valid output stays low and frame strobes leave its pending data and busy flag untouched. Setting the enable again emits the same data.
- R7: An incoming tag strobe with a slot's tag bit set, while that slot's receive enable is set, raises its receive busy flag. The following slot strobe stores the slot word, clears receive busy and sets receive valid.
- R8: With a slot's receive enable clear, incoming tags and words leave its busy flag, its valid flag and its stored word unchanged.
- R9: A host read of a receive register returns the stored word and clears that slot's valid flag. A later capture overwrites the stored word and sets valid again.
- R10: Control bits 11:10 select the target codec (0 to 3) and drive the codec-select output. Control bits 0 to 3 are slot-1 transmit enable, slot-1 receive enable, slot-2 transmit enable and slot-2 receive enable.
- R11: Flag register layout, counting from bit 0 upward: s1 RX busy, s1 TX busy, s2 RX busy, s2 TX busy, s12 RX busy (0), s12 TX busy (0), s1 RX valid, s1 TX empty, s2 RX valid, s2 TX empty, s12 RX valid (0), s12 TX empty (1).
- R12: A second host write to a pending transmit register replaces the staged value. The last write is the one emitted.
- R13: Register indices are: 0 slot-1 transmit, 1 slot-2 transmit, 2 slot-1 receive, 3 slot-2 receive, 4 flags, 5 control. Read data appears with its valid strobe one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_i | input | 1 | Host register write strobe |
| host_rd_i | input | 1 | Host register read strobe |
| host_addr_i | input | HOST_AW | Host register index |
| host_wdata_i | input | HOST_DW | Host write data |
| host_rdata_o | output | HOST_DW | Registered read data |
| host_rvalid_o | output | 1 | Read data valid, one cycle after the read |
| out_tag_stb_i | input | 1 | One-cycle outgoing frame tag strobe |
| out_s1_vld_o | output | 1 | Slot 1 tagged valid in the outgoing frame |
| out_s2_vld_o | output | 1 | Slot 2 tagged valid in the outgoing frame |
| out_s1_word_o | output | SLOT_W | Outgoing command-address slot word |
| out_s2_word_o | output | SLOT_W | Outgoing command-data slot word |
| out_codec_sel_o | output | SEL_W | Target codec index |
| in_tag_stb_i | input | 1 | Incoming frame tag strobe |
| in_tag_s1_i | input | 1 | Incoming frame carries valid slot 1 |
| in_tag_s2_i | input | 1 | Incoming frame carries valid slot 2 |
| in_slot_stb_i | input | 1 | Incoming slot words present |
| in_s1_word_i | input | SLOT_W | Incoming status-address slot word |
| in_s2_word_i | input | SLOT_W | Incoming status-data slot word |

## Verification
The bench builds the block with its default parameters: a 3-bit host index, a 32-bit host word, 20-bit slots and four codecs. With these values every register index, all four codec-select codes and all twelve flag bits can be reached through the host port. It drives write-then-launch ordering, read requests, held transmissions under a cleared enable, back-to-back status overwrites and ignored receive slots. Each of these is checked in the flag register and on the slot outputs at the cycle the requirements predict.

// File: rtl/cra_pkg.sv
// Package: shared constants of the codec register access unit.
// Assumes: slot words are 20 bits wide, as on an AC'97-style link.
package cra_pkg;
    localparam int SLOT_W = 20;

    // Host register indices
    localparam int IDX_S1_TX = 0;
    localparam int IDX_S2_TX = 1;
    localparam int IDX_S1_RX = 2;
    localparam int IDX_S2_RX = 3;
    localparam int IDX_FLAGS = 4;
    localparam int IDX_CTRL  = 5;

    // Flag bit positions (software decodes these)
    localparam int FLAG_W      = 12;
    localparam int FLG_S1_RXB  = 0;
    localparam int FLG_S1_TXB  = 1;
    localparam int FLG_S2_RXB  = 2;
    localparam int FLG_S2_TXB  = 3;
    localparam int FLG_S12_RXB = 4;
    localparam int FLG_S12_TXB = 5;
    localparam int FLG_S1_RXV  = 6;
    localparam int FLG_S1_TXE  = 7;
    localparam int FLG_S2_RXV  = 8;
    localparam int FLG_S2_TXE  = 9;
    localparam int FLG_S12_RXV = 10;
    localparam int FLG_S12_TXE = 11;

    // Control bit positions
    localparam int CTL_S1_TXEN = 0;
    localparam int CTL_S1_RXEN = 1;
    localparam int CTL_S2_TXEN = 2;
    localparam int CTL_S2_RXEN = 3;
    localparam int CTL_SEL_LSB = 10;

    // Kept fields of the transmit slot words
    localparam int S1_HI = 19;
    localparam int S1_LO = 12;
    localparam int S2_HI = 19;
    localparam int S2_LO = 4;
endpackage

// File: rtl/cra_tx_hold.sv
// Module: transmit holding register for one command slot.
// Keeps the field [KEEP_HI:KEEP_LO] of the host word and tracks whether it
// is waiting for a frame. A load takes priority over a same-cycle emit.
// Assumes: emit_i is asserted only while pend_o is high.
module cra_tx_hold #(
    parameter int SLOT_W  = 20,
    parameter int KEEP_HI = 19,
    parameter int KEEP_LO = 12,
    localparam int FLD_W  = KEEP_HI - KEEP_LO + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [FLD_W-1:0]  load_fld_i,
    input  logic              emit_i,
    output logic              pend_o,
    output logic [SLOT_W-1:0] word_o
);
    logic             pend_q;
    logic [FLD_W-1:0] fld_q;

    // Stage the field on a host write and retire it when the frame takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            fld_q  <= '0;
        end else if (load_i) begin
            pend_q <= 1'b1;
            fld_q  <= load_fld_i;
        end else if (emit_i) begin
            pend_q <= 1'b0;
        end
    end

    // Place the kept field back at its slot position, other bits zero
    always_comb begin
        word_o                  = '0;
        word_o[KEEP_HI:KEEP_LO] = fld_q;
    end

    assign pend_o = pend_q;

    // R5: busy drops only after the slot was emitted
    p_busy_clears_on_emit_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_q) |-> $past(emit_i));

    // R5: a host write always leaves the slot busy
    p_busy_sets_on_load_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> pend_q);
endmodule

// File: rtl/cra_rx_hold.sv
// Module: receive holding register for one status slot.
// A tag strobe marks the slot as arriving (busy). The next slot strobe
// stores the word and sets valid. A host read clears valid, but a capture
// in the same cycle wins. Assumes: tag and slot strobes never coincide.
module cra_rx_hold #(
    parameter int SLOT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tag_stb_i,
    input  logic              tag_bit_i,
    input  logic              slot_stb_i,
    input  logic [SLOT_W-1:0] slot_word_i,
    input  logic              host_rd_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic [SLOT_W-1:0] word_o
);
    logic              busy_q;
    logic              valid_q;
    logic [SLOT_W-1:0] word_q;

    // Track the arrival window, capture the word, clear valid on a host read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
            word_q  <= '0;
        end else begin
            if (tag_stb_i && tag_bit_i && en_i)
                busy_q <= 1'b1;
            else if (slot_stb_i)
                busy_q <= 1'b0;

            if (slot_stb_i && busy_q && en_i) begin
                word_q  <= slot_word_i;
                valid_q <= 1'b1;
            end else if (host_rd_i) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign busy_o  = busy_q;
    assign valid_o = valid_q;
    assign word_o  = word_q;

    // R7: valid rises only on an enabled slot strobe
    p_valid_on_capture_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $past(slot_stb_i && en_i));

    // R9: a host read without a competing capture clears valid
    p_read_clears_valid_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && !slot_stb_i) |=> !valid_q);

    // R8: with receive disabled the stored word never changes
    p_disabled_holds_word_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(word_q));
endmodule

// File: rtl/codec_reg_access.sv
// Module: codec register access unit (top).
// The host stages command data (slot 2) and the command address (slot 1).
// Loading slot 1 launches the command. The next outgoing frame tag strobe
// emits slot 1 and, if pending, slot 2. Status words from incoming frames
// are held per slot until the host reads them.
// Assumes: HOST_DW > SLOT_W; NUM_CODECS <= 4 so the select fits bits 11:10.
module codec_reg_access
    import cra_pkg::*;
#(
    parameter int HOST_AW    = 3,
    parameter int HOST_DW    = 32,
    parameter int NUM_CODECS = 4,
    localparam int SEL_W     = (NUM_CODECS > 1) ? $clog2(NUM_CODECS) : 1,
    localparam int NUM_RX    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_i,
    input  logic               host_rd_i,
    input  logic [HOST_AW-1:0] host_addr_i,
    input  logic [HOST_DW-1:0] host_wdata_i,
    output logic [HOST_DW-1:0] host_rdata_o,
    output logic               host_rvalid_o,
    input  logic               out_tag_stb_i,
    output logic               out_s1_vld_o,
    output logic               out_s2_vld_o,
    output logic [SLOT_W-1:0]  out_s1_word_o,
    output logic [SLOT_W-1:0]  out_s2_word_o,
    output logic [SEL_W-1:0]   out_codec_sel_o,
    input  logic               in_tag_stb_i,
    input  logic               in_tag_s1_i,
    input  logic               in_tag_s2_i,
    input  logic               in_slot_stb_i,
    input  logic [SLOT_W-1:0]  in_s1_word_i,
    input  logic [SLOT_W-1:0]  in_s2_word_i
);
    logic [3:0]        en_q;
    logic [SEL_W-1:0]  sel_q;
    logic              wr_s1, wr_s2, wr_ctl;
    logic              s1_pend, s2_pend;
    logic              s1_emit, s2_emit;
    logic [FLAG_W-1:0] flags;
    logic [HOST_DW-1:0] rd_mux;
    logic              unused_wbits;

    logic [NUM_RX-1:0]             rx_en, rx_tag, rx_rd, rx_busy, rx_valid;
    logic [NUM_RX-1:0][SLOT_W-1:0] rx_in, rx_word;

    assign unused_wbits = ^host_wdata_i[HOST_DW-1:SLOT_W];

    // Decode host writes per register
    assign wr_s1  = host_wr_i && (host_addr_i == HOST_AW'(IDX_S1_TX));
    assign wr_s2  = host_wr_i && (host_addr_i == HOST_AW'(IDX_S2_TX));
    assign wr_ctl = host_wr_i && (host_addr_i == HOST_AW'(IDX_CTRL));

    // Control register: slot enables and codec select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
        end else if (wr_ctl) begin
            en_q  <= host_wdata_i[3:0];
            sel_q <= host_wdata_i[CTL_SEL_LSB +: SEL_W];
        end
    end

    assign out_codec_sel_o = sel_q;

    // Slot 1 launches; slot 2 rides along only in a frame that carries slot 1
    assign out_s1_vld_o = s1_pend && en_q[CTL_S1_TXEN];
    assign out_s2_vld_o = out_s1_vld_o && s2_pend && en_q[CTL_S2_TXEN];
    assign s1_emit      = out_tag_stb_i && out_s1_vld_o;
    assign s2_emit      = out_tag_stb_i && out_s2_vld_o;

    cra_tx_hold #(.SLOT_W(SLOT_W), .KEEP_HI(S1_HI), .KEEP_LO(S1_LO)) u_tx_s1 (
        .clk(clk), .rst_n(rst_n), .load_i(wr_s1),
        .load_fld_i(host_wdata_i[S1_HI:S1_LO]), .emit_i(s1_emit),
        .pend_o(s1_pend), .word_o(out_s1_word_o));

    cra_tx_hold #(.SLOT_W(SLOT_W), .KEEP_HI(S2_HI), .KEEP_LO(S2_LO)) u_tx_s2 (
        .clk(clk), .rst_n(rst_n), .load_i(wr_s2),
        .load_fld_i(host_wdata_i[S2_HI:S2_LO]), .emit_i(s2_emit),
        .pend_o(s2_pend), .word_o(out_s2_word_o));

    // Map per-slot receive inputs onto the replicated holders
    assign rx_en  = {en_q[CTL_S2_RXEN], en_q[CTL_S1_RXEN]};
    assign rx_tag = {in_tag_s2_i, in_tag_s1_i};
    assign rx_in  = {in_s2_word_i, in_s1_word_i};

    for (genvar g = 0; g < NUM_RX; g++) begin : g_rx
        assign rx_rd[g] = host_rd_i && (host_addr_i == HOST_AW'(IDX_S1_RX + g));
        cra_rx_hold #(.SLOT_W(SLOT_W)) u_rx (
            .clk(clk), .rst_n(rst_n), .en_i(rx_en[g]),
            .tag_stb_i(in_tag_stb_i), .tag_bit_i(rx_tag[g]),
            .slot_stb_i(in_slot_stb_i), .slot_word_i(rx_in[g]),
            .host_rd_i(rx_rd[g]), .busy_o(rx_busy[g]),
            .valid_o(rx_valid[g]), .word_o(rx_word[g]));
    end

    // Assemble the flag register at its fixed bit positions
    always_comb begin
        flags              = '0;
        flags[FLG_S1_RXB]  = rx_busy[0];
        flags[FLG_S1_TXB]  = s1_pend;
        flags[FLG_S2_RXB]  = rx_busy[1];
        flags[FLG_S2_TXB]  = s2_pend;
        flags[FLG_S12_RXB] = 1'b0;
        flags[FLG_S12_TXB] = 1'b0;
        flags[FLG_S1_RXV]  = rx_valid[0];
        flags[FLG_S1_TXE]  = !s1_pend;
        flags[FLG_S2_RXV]  = rx_valid[1];
        flags[FLG_S2_TXE]  = !s2_pend;
        flags[FLG_S12_RXV] = 1'b0;
        flags[FLG_S12_TXE] = 1'b1;
    end

    // Select read data by register index
    always_comb begin
        rd_mux = '0;
        case (host_addr_i)
            HOST_AW'(IDX_S1_TX): rd_mux = HOST_DW'(out_s1_word_o);
            HOST_AW'(IDX_S2_TX): rd_mux = HOST_DW'(out_s2_word_o);
            HOST_AW'(IDX_S1_RX): rd_mux = HOST_DW'(rx_word[0]);
            HOST_AW'(IDX_S2_RX): rd_mux = HOST_DW'(rx_word[1]);
            HOST_AW'(IDX_FLAGS): rd_mux = HOST_DW'(flags);
            HOST_AW'(IDX_CTRL): begin
                rd_mux[3:0]                  = en_q;
                rd_mux[CTL_SEL_LSB +: SEL_W] = sel_q;
            end
            default: rd_mux = '0;
        endcase
    end

    // Register read data and its valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata_o  <= '0;
            host_rvalid_o <= 1'b0;
        end else begin
            host_rvalid_o <= host_rd_i;
            if (host_rd_i)
                host_rdata_o <= rd_mux;
        end
    end

    // R4: slot 2 is never tagged without slot 1
    p_s2_rides_with_s1_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        out_s2_vld_o |-> out_s1_vld_o);

    // R6: a frame strobe with transmit disabled keeps slot 1 pending
    p_disabled_tx_holds_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (out_tag_stb_i && s1_pend && !en_q[CTL_S1_TXEN] && !wr_s1) |=> s1_pend);

    // R13: read data valid follows a read request by exactly one cycle
    p_rvalid_follows_read_r13 : assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_i |=> host_rvalid_o);
endmodule

// File: tb/codec_reg_access_tb_top.sv
// Scoreboard bench for the codec register access unit.
module codec_reg_access_tb_top;
    localparam int AW = 3;
    localparam int DW = 32;
    localparam int SW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0, host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_rvalid;
    logic          out_tag_stb = 1'b0;
    logic          s1_vld, s2_vld;
    logic [SW-1:0] s1_word, s2_word;
    logic [1:0]    codec_sel;
    logic          in_tag_stb = 1'b0, in_tag_s1 = 1'b0, in_tag_s2 = 1'b0;
    logic          in_slot_stb = 1'b0;
    logic [SW-1:0] in_s1 = '0, in_s2 = '0;

    int n_cmp = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #5 clk = ~clk;

    codec_reg_access dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr_i(host_wr), .host_rd_i(host_rd), .host_addr_i(host_addr),
        .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
        .host_rvalid_o(host_rvalid), .out_tag_stb_i(out_tag_stb),
        .out_s1_vld_o(s1_vld), .out_s2_vld_o(s2_vld),
        .out_s1_word_o(s1_word), .out_s2_word_o(s2_word),
        .out_codec_sel_o(codec_sel), .in_tag_stb_i(in_tag_stb),
        .in_tag_s1_i(in_tag_s1), .in_tag_s2_i(in_tag_s2),
        .in_slot_stb_i(in_slot_stb), .in_s1_word_i(in_s1), .in_s2_word_i(in_s2));

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [DW-1:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = AW'(idx); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // Driver: issue a read and push the expected value
    task automatic rd(input int idx, input logic [DW-1:0] e, input string req);
        @(negedge clk);
        host_rd = 1'b1; host_addr = AW'(idx);
        exp_q.push_back(e); tag_q.push_back(req);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic tx_frame();
        @(negedge clk); out_tag_stb = 1'b1;
        @(negedge clk); out_tag_stb = 1'b0;
    endtask

    task automatic rx_tag(input logic t1, input logic t2);
        @(negedge clk); in_tag_stb = 1'b1; in_tag_s1 = t1; in_tag_s2 = t2;
        @(negedge clk); in_tag_stb = 1'b0; in_tag_s1 = 1'b0; in_tag_s2 = 1'b0;
    endtask

    task automatic rx_slot(input logic [SW-1:0] w1, input logic [SW-1:0] w2);
        @(negedge clk); in_slot_stb = 1'b1; in_s1 = w1; in_s2 = w2;
        @(negedge clk); in_slot_stb = 1'b0;
    endtask

    // Monitor: pop and compare each returned read
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R13: unexpected read data 0x%0h expected none", host_rdata);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (host_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", t, host_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 R11: reset state
        rd(4, 32'h0A80, "R1 flags after reset");
        rd(5, 32'h0, "R1 control after reset");
        check("R1 s1 tag", {31'b0, s1_vld}, 32'h0);
        check("R1 s2 tag", {31'b0, s2_vld}, 32'h0);
        // R10: enables and codec select
        wr(5, 32'h80F);
        rd(5, 32'h80F, "R10 control readback");
        check("R10 codec select", {30'b0, codec_sel}, 32'h2);
        // R4 R5: slot 2 staged alone stays untagged
        wr(1, 32'h000ABCD7);
        check("R4 s2 alone untagged", {31'b0, s2_vld}, 32'h0);
        rd(4, 32'h0888, "R5 s2 busy flags");
        // R2 R3: launch write command
        wr(0, 32'h00026000);
        check("R2 s1 word", {12'b0, s1_word}, 32'h26000);
        check("R3 s2 word", {12'b0, s2_word}, 32'hABCD0);
        check("R4 s1 tag", {31'b0, s1_vld}, 32'h1);
        check("R4 s2 tag with s1", {31'b0, s2_vld}, 32'h1);
        rd(4, 32'h080A, "R11 both tx busy");
        tx_frame();
        rd(4, 32'h0A80, "R5 flags after emit");
        check("R5 s1 tag cleared", {31'b0, s1_vld}, 32'h0);
        // R2: read request drops low bits
        wr(0, 32'h000FCFFF);
        check("R2 read request word", {12'b0, s1_word}, 32'hFC000);
        check("R4 s2 not tagged", {31'b0, s2_vld}, 32'h0);
        tx_frame();
        // R12: last write wins
        wr(0, 32'h00011000);
        wr(0, 32'h00022000);
        check("R12 overwrite", {12'b0, s1_word}, 32'h22000);
        // R6: disabled transmit holds data
        wr(5, 32'h80E);
        check("R6 tag low when disabled", {31'b0, s1_vld}, 32'h0);
        tx_frame();
        rd(4, 32'h0A02, "R6 still busy");
        wr(5, 32'h80F);
        check("R6 held word", {12'b0, s1_word}, 32'h22000);
        tx_frame();
        rd(4, 32'h0A80, "R6 emitted after re-enable");
        // R7 R9: status capture and read
        rx_tag(1'b1, 1'b1);
        rd(4, 32'h0A85, "R7 rx busy");
        rx_slot(20'h7C000, 20'h5A5A0);
        rd(4, 32'h0BC0, "R7 rx valid");
        rd(2, 32'h7C000, "R9 s1 status");
        rd(4, 32'h0B80, "R9 s1 valid cleared");
        rd(3, 32'h5A5A0, "R9 s2 status");
        rd(4, 32'h0A80, "R9 s2 valid cleared");
        rx_tag(1'b1, 1'b0); rx_slot(20'h13000, 20'h0);
        rx_tag(1'b1, 1'b0); rx_slot(20'h14000, 20'h0);
        rd(2, 32'h14000, "R9 overwrite");
        // R8: receive disabled is ignored
        wr(5, 32'h80D);
        rx_tag(1'b1, 1'b0);
        rd(4, 32'h0A80, "R8 no busy");
        rx_slot(20'h15000, 20'h0);
        rd(4, 32'h0A80, "R8 no valid");
        rd(2, 32'h14000, "R8 word kept");
        // R10 R13: select 3, unused index reads zero
        wr(5, 32'hC0F);
        check("R10 codec select 3", {30'b0, codec_sel}, 32'h3);
        rd(7, 32'h0, "R13 unused index");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R13: %0d reads unanswered expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end
endmodule